// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical page number. It walks a tree of page tables held in memory, starting at a root table base that the caller supplies with each request. At every level it reads one 32-bit descriptor through a memory port that allows one access at a time. The descriptor's two low bits give its kind: a link to the next table, a final page entry, or an entry that cannot be used. The walk stops at the first final entry it finds. That entry's 3-bit permission code is then checked against the requested access: read, write or instruction fetch.

When the access is allowed, the block sets the referenced flag in the page entry. For a write it also sets the modified flag. The entry is stored back only if one of these flags actually changes. The response carries the page number and the cacheable flag, and it is issued only after that store has completed. If the walk or the permission check fails, the response carries a fault kind and the level at which the failure happened.

Top module: `page_walker`

## Requirements
- R1: The virtual page number is split into index fields: bits 31:24 index the level-0 table, bits 23:18 the level-1 table and bits 17:12 the level-2 table. The level-0 table starts at `root_base`. A descriptor whose type field (bits 1:0) is 1 is a table link, and the next table starts at `{desc[31:8], 8'h00}`. Each descriptor is read at the table base plus four times the index.
- R2: A descriptor of type 2 is a page entry. A permitted access returns `rsp_fault` = 0, `rsp_ppn` = descriptor bits 31:8 and `rsp_cacheable` = descriptor bit 7.
- R3: A descriptor of type 0 or type 3 ends the walk with `rsp_fault` = 1. `rsp_level` then holds the level (0, 1 or 2) of the table that held the descriptor.
- R4: A table link read from the level-2 table ends the walk with `rsp_fault` = 1 and `rsp_level` = 2.
- R5: The permission code sits in bits 4:2 of the page entry. Bit 4 allows reads, bit 3 allows writes and bit 2 allows fetches. `req_acc` encodes 0 as read, 1 as write, 2 as fetch, and 3 is never allowed. A forbidden access gives `rsp_fault` = 2 and `rsp_level` = the level of the entry, and the entry is not written.
- R6: A permitted access stores the entry back to the address it was read from. The stored entry has the referenced flag (bit 5) set, and for a write also the modified flag (bit 6). All other bits are unchanged.
- R7: When the flags that R6 would set are already set, no store is made.
- R8: `rsp_valid` is a one-cycle pulse that comes only after the last memory access of the walk has been acknowledged. On any fault, `rsp_ppn` and `rsp_cacheable` are zero.
- R9: Only one walk runs at a time: `req_ready` is high only while idle. `mem_req` is held, with a stable address and direction, until `mem_ack` arrives, and every memory address is 4-byte aligned.
- R10: After reset the block is idle, with `req_ready` high and `mem_req` and `rsp_valid` low.
- R11: A page entry found at level 0 or level 1 ends the walk there and is handled as in R2, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| root_base | input | 32 | Byte address of the level-0 table |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | 32 | Descriptor byte address |
| mem_wdata | output | 32 | Descriptor to store |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Descriptor read |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 2 | 0 none, 1 translation, 2 protection |
| rsp_level | output | 2 | Level of the final or failing descriptor |
| rsp_ppn | output | 24 | Physical page number |
| rsp_cacheable | output | 1 | Page may be cached |

## Verification
A wrong level counter or base register shows up on `mem_addr` at the very next descriptor read. In that case the bench's memory returns the wrong descriptor, and the response comes back with the wrong fault kind, level or page number within the same walk. A wrong flag update is visible in the stored word, or in a store appearing when none should be made, before the response pulse. The bench therefore counts the stores made during each walk and reads the table contents back afterwards. A stuck state machine never raises `rsp_valid`, and the bench's wait for that pulse catches it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RESP} walk_state_t;

  localparam logic [1:0] DT_INVALID = 2'd0;
  localparam logic [1:0] DT_TABLE   = 2'd1;
  localparam logic [1:0] DT_LEAF    = 2'd2;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] FLT_NONE  = 2'd0;
  localparam logic [1:0] FLT_XLATE = 2'd1;
  localparam logic [1:0] FLT_PROT  = 2'd2;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX0_W = 8,
  parameter int IDX1_W = 6,
  parameter int IDX2_W = 6
) (
  input  logic [ADDR_W-OFF_W-1:0] vpn,
  input  logic [1:0]              level,
  input  logic [ADDR_W-1:0]       base,
  output logic [ADDR_W-1:0]       addr
);
  localparam int VPN_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] idx_ext [3];
  logic [ADDR_W-1:0] idx_sel;

  assign idx_ext[0] = ADDR_W'(vpn[VPN_W-1 -: IDX0_W]);
  assign idx_ext[1] = ADDR_W'(vpn[IDX2_W +: IDX1_W]);
  assign idx_ext[2] = ADDR_W'(vpn[0 +: IDX2_W]);

  always_comb begin
    case (level)
      2'd0:    idx_sel = idx_ext[0];
      2'd1:    idx_sel = idx_ext[1];
      default: idx_sel = idx_ext[2];
    endcase
  end

  assign addr = base + (idx_sel << 2);
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
(
  input  logic [31:0] desc,
  input  logic [1:0]  acc,
  output logic        allowed,
  output logic [31:0] new_desc,
  output logic        changed
);
  logic [2:0] perm;
  assign perm = desc[4:2];

  always_comb begin
    case (acc)
      ACC_READ:  allowed = perm[2];
      ACC_WRITE: allowed = perm[1];
      ACC_EXEC:  allowed = perm[0];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    new_desc          = desc;
    new_desc[REF_BIT] = 1'b1;
    if (acc == ACC_WRITE) new_desc[MOD_BIT] = 1'b1;
  end

  assign changed = (new_desc != desc);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX0_W = 8,
  parameter int IDX1_W = 6,
  parameter int IDX2_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_fault,
  output logic [1:0]        rsp_level,
  output logic [23:0]       rsp_ppn,
  output logic              rsp_cacheable
);
  localparam int         VPN_W      = ADDR_W - OFF_W;
  localparam logic [1:0] LAST_LEVEL = 2'd2;

  logic              rst_n_int;
  walk_state_t       state_q, state_d;
  logic [1:0]        level_q, level_d;
  logic [VPN_W-1:0]  vpn_q;
  logic [1:0]        acc_q;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [31:0]       wdata_q, wdata_d;
  logic [1:0]        fault_q, fault_d;
  logic [23:0]       ppn_q, ppn_d;
  logic              cach_q, cach_d;
  logic              cap_req;
  logic [ADDR_W-1:0] walk_addr;
  logic [ADDR_W-1:0] next_base;
  logic              leaf_ok;
  logic [31:0]       leaf_new;
  logic              leaf_chg;
  logic              unused_off;

  assign unused_off = ^req_vaddr[OFF_W-1:0];

  ptw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ptw_addr_gen #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX0_W (IDX0_W),
    .IDX1_W (IDX1_W),
    .IDX2_W (IDX2_W)
  ) u_addr (
    .vpn   (vpn_q),
    .level (level_q),
    .base  (base_q),
    .addr  (walk_addr)
  );

  ptw_leaf_eval u_leaf (
    .desc     (mem_rdata),
    .acc      (acc_q),
    .allowed  (leaf_ok),
    .new_desc (leaf_new),
    .changed  (leaf_chg)
  );

  assign cap_req   = (state_q == ST_IDLE) && req_valid;
  assign next_base = ADDR_W'({mem_rdata[31:8], 8'h00});

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    base_d  = base_q;
    wdata_d = wdata_q;
    fault_d = fault_q;
    ppn_d   = ppn_q;
    cach_d  = cach_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_READ;
          level_d = 2'd0;
          base_d  = root_base;
          fault_d = FLT_NONE;
          ppn_d   = '0;
          cach_d  = 1'b0;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          case (mem_rdata[1:0])
            DT_TABLE: begin
              if (level_q == LAST_LEVEL) begin
                fault_d = FLT_XLATE;
                state_d = ST_RESP;
              end else begin
                level_d = level_q + 2'd1;
                base_d  = next_base;
              end
            end
            DT_LEAF: begin
              if (!leaf_ok) begin
                fault_d = FLT_PROT;
                state_d = ST_RESP;
              end else begin
                ppn_d   = mem_rdata[31:8];
                cach_d  = mem_rdata[7];
                wdata_d = leaf_new;
                state_d = leaf_chg ? ST_WRITE : ST_RESP;
              end
            end
            default: begin
              fault_d = FLT_XLATE;
              state_d = ST_RESP;
            end
          endcase
        end
      end
      ST_WRITE: begin
        if (mem_ack) state_d = ST_RESP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      level_q <= 2'd0;
      base_q  <= '0;
      wdata_q <= '0;
      fault_q <= FLT_NONE;
      ppn_q   <= '0;
      cach_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
      base_q  <= base_d;
      wdata_q <= wdata_d;
      fault_q <= fault_d;
      ppn_q   <= ppn_d;
      cach_q  <= cach_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vpn_q <= '0;
      acc_q <= ACC_READ;
    end else if (cap_req) begin
      vpn_q <= req_vaddr[ADDR_W-1:OFF_W];
      acc_q <= req_acc;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req       = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we        = (state_q == ST_WRITE);
  assign mem_addr      = walk_addr;
  assign mem_wdata     = wdata_q;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_level     = level_q;
  assign rsp_ppn       = ppn_q;
  assign rsp_cacheable = cach_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        rsp_valid,
  input logic [1:0]  rsp_fault,
  input logic [23:0] rsp_ppn,
  input logic        rsp_cacheable
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R9

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req); // R9

  AST_STORE_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[1:0] == 2'd2)); // R6

  AST_STORE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $rose(mem_we)) |-> $stable(mem_addr)); // R6

  AST_RSP_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_ppn == 24'd0 && !rsp_cacheable)); // R8
endmodule

bind page_walker ptw_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_ack       (mem_ack),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_ppn       (rsp_ppn),
  .rsp_cacheable (rsp_cacheable)
);

// File: tb/sim_page_walker.sv
`timescale 1ns/1ps
module sim_page_walker;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic [31:0] root_base;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [1:0]  rsp_level;
  logic [23:0] rsp_ppn;
  logic        rsp_cacheable;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  int mem_delay = 0;
  int wait_cnt = 0;
  int busy_viol = 0;
  logic [31:0] mem [4096];

  page_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .root_base(root_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_ppn(rsp_ppn), .rsp_cacheable(rsp_cacheable)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mkdesc(input logic [23:0] ppn, input logic c,
      input logic m, input logic r, input logic [2:0] perm, input logic [1:0] ty);
    return {ppn, c, m, r, perm, ty};
  endfunction

  // Vector: vaddr, acc, fault, level, ppn, cacheable, store expected
  localparam int NVEC = 13;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h01080000, 2'd0, 2'd0, 2'd2, 24'h000ABC, 1'b1, 1'b1}, // R1 R2 R6 read sets ref
    {32'h01080FFC, 2'd0, 2'd0, 2'd2, 24'h000ABC, 1'b1, 1'b0}, // R7 ref already set
    {32'h01080010, 2'd1, 2'd0, 2'd2, 24'h000ABC, 1'b1, 1'b1}, // R6 write sets mod
    {32'h01080020, 2'd1, 2'd0, 2'd2, 24'h000ABC, 1'b1, 1'b0}, // R7
    {32'h01080000, 2'd2, 2'd2, 2'd2, 24'h000000, 1'b0, 1'b0}, // R5 fetch denied
    {32'h01081000, 2'd2, 2'd0, 2'd2, 24'h012345, 1'b0, 1'b0}, // R2 R7 uncached fetch
    {32'h01081000, 2'd0, 2'd2, 2'd2, 24'h000000, 1'b0, 1'b0}, // R5 read denied
    {32'h01082000, 2'd0, 2'd1, 2'd2, 24'h000000, 1'b0, 1'b0}, // R3 invalid at level 2
    {32'h01083000, 2'd0, 2'd1, 2'd2, 24'h000000, 1'b0, 1'b0}, // R4 link at last level
    {32'h01084000, 2'd1, 2'd2, 2'd2, 24'h000000, 1'b0, 1'b0}, // R5 write denied
    {32'h02000000, 2'd0, 2'd1, 2'd0, 24'h000000, 1'b0, 1'b0}, // R3 type 3 at level 0
    {32'h03000000, 2'd0, 2'd1, 2'd1, 24'h000000, 1'b0, 1'b0}, // R3 invalid at level 1
    {32'h04123456, 2'd0, 2'd0, 2'd0, 24'h000777, 1'b1, 1'b1}  // R11 page at level 0
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory responder: ack after mem_delay idle cycles, cleared the next cycle
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && req_ready) busy_viol++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt < mem_delay) wait_cnt++;
        else begin
          wait_cnt = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr[13:2]] = mem_wdata;
            wr_count++;
          end else mem_rdata = mem[mem_addr[13:2]];
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                      output logic [1:0] f, output logic [1:0] l,
                      output logic [23:0] p, output logic c, output int nwr);
    int base_wr;
    int guard;
    base_wr = wr_count;
    @(negedge clk);
    req_vaddr = va;
    req_acc = acc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    f = rsp_fault; l = rsp_level; p = rsp_ppn; c = rsp_cacheable;
    nwr = wr_count - base_wr;
    if (!rsp_valid) check(1'b0, "R8", "no response", 64'd0, 64'd1);
  endtask

  initial begin
    logic [1:0] f, l;
    logic [23:0] p;
    logic c;
    int nwr;
    string tag;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_acc = '0;
    root_base = 32'h0000_0000;
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    mem[1]       = 32'h0000_0401;                                   // level 0 -> 0x400
    mem[2]       = 32'h0000_0003;                                   // reserved type
    mem[3]       = 32'h0000_0601;                                   // level 0 -> 0x600
    mem[4]       = mkdesc(24'h000777, 1'b1, 1'b0, 1'b0, 3'b111, 2'd2);
    mem[12'h102] = 32'h0000_0501;                                   // level 1 -> 0x500
    mem[12'h180] = 32'h0000_0000;
    mem[12'h140] = mkdesc(24'h000ABC, 1'b1, 1'b0, 1'b0, 3'b110, 2'd2);
    mem[12'h141] = mkdesc(24'h012345, 1'b0, 1'b0, 1'b1, 3'b001, 2'd2);
    mem[12'h142] = 32'h0000_0000;
    mem[12'h143] = 32'h0000_0901;
    mem[12'h144] = mkdesc(24'h000055, 1'b1, 1'b0, 1'b0, 3'b100, 2'd2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check(req_ready && !mem_req && !rsp_valid, "R10", "reset state",
          {61'd0, req_ready, mem_req, rsp_valid}, 64'd4);

    for (int i = 0; i < NVEC; i++) begin
      walk(VEC[i][63:32], VEC[i][31:30], f, l, p, c, nwr);
      tag = (VEC[i][29:28] == 2'd0) ? "R2" : (VEC[i][29:28] == 2'd1) ? "R3" : "R5";
      check({f, l, p, c} == VEC[i][29:1], tag, $sformatf("vector %0d response", i),
            {35'd0, f, l, p, c}, {35'd0, VEC[i][29:1]});
      check(nwr == int'(VEC[i][0]), VEC[i][0] ? "R6" : "R7",
            $sformatf("vector %0d store count", i), 64'(nwr), 64'(VEC[i][0]));
    end

    check(mem[12'h140] == mkdesc(24'h000ABC, 1'b1, 1'b1, 1'b1, 3'b110, 2'd2), "R6",
          "level 2 entry flags", {32'd0, mem[12'h140]},
          {32'd0, mkdesc(24'h000ABC, 1'b1, 1'b1, 1'b1, 3'b110, 2'd2)});
    check(mem[4] == mkdesc(24'h000777, 1'b1, 1'b0, 1'b1, 3'b111, 2'd2), "R11",
          "level 0 entry flags", {32'd0, mem[4]},
          {32'd0, mkdesc(24'h000777, 1'b1, 1'b0, 1'b1, 3'b111, 2'd2)});
    check(mem[12'h144] == mkdesc(24'h000055, 1'b1, 1'b0, 1'b0, 3'b100, 2'd2), "R5",
          "denied entry untouched", {32'd0, mem[12'h144]},
          {32'd0, mkdesc(24'h000055, 1'b1, 1'b0, 1'b0, 3'b100, 2'd2)});

    // R5: access code 3 never allowed
    walk(32'h04000000, 2'd3, f, l, p, c, nwr);
    check(f == 2'd2 && l == 2'd0 && nwr == 0, "R5", "access code 3",
          {58'd0, f, l, nwr[1:0]}, {58'd0, 2'd2, 2'd0, 2'd0});

    // R9: slow memory, walk still correct
    mem_delay = 3;
    walk(32'h01081000, 2'd2, f, l, p, c, nwr);
    check(f == 2'd0 && p == 24'h012345 && !c && nwr == 0, "R9", "slow memory walk",
          {37'd0, f, p, c}, {37'd0, 2'd0, 24'h012345, 1'b0});
    // R6: write with slow memory to level 0 page sets modified
    walk(32'h04000000, 2'd1, f, l, p, c, nwr);
    check(f == 2'd0 && nwr == 1 && mem[4][6] && mem[4][5], "R6", "slow store",
          {60'd0, f, mem[4][6:5]}, {60'd0, 2'd0, 2'b11});
    mem_delay = 0;

    // R1: non-zero root base
    root_base = 32'h0000_0800;
    mem[12'h201] = 32'h0000_0401;
    walk(32'h01080000, 2'd0, f, l, p, c, nwr);
    check(f == 2'd0 && p == 24'h000ABC && nwr == 0, "R1", "moved root",
          {38'd0, f, p}, {38'd0, 2'd0, 24'h000ABC});

    check(busy_viol == 0, "R9", "ready while busy", 64'(busy_viol), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule